// File: doc/BRIEF.md
# Flag Pin Interrupt Unit

This block manages a bank of general-purpose flag pins. Each pin is either an output, driven from a data register, or an input that passes through a two-flop synchronizer and can raise a hardware interrupt. Software can also post an interrupt on any pin by writing a trigger register.

Each input pin picks its own detection: level (active-high or active-low), single edge (rising or falling) or both edges. Edge events are held in a sticky status bit until software clears it by writing 1. Two interrupt lines, A and B, each assert while any pin enabled in that line's mask is active. A pin counts as active while its sticky status bit is set or, in level mode, while its level matches the polarity. Software reaches the block through a simple write strobe and address, with a combinational read path.

Top module: `flag_irq_unit`

## Requirements
- R1: After reset every register reads 0, so all pins are inputs in level mode with no mask set, and pad_oe_o, irq_a_o and irq_b_o are low.
- R2: Register offset 0 is the direction register (1 = output) and offset 1 is the data register. For a pin set as output, pad_oe_o is 1 and pad_o carries its data bit.
- R3: A read of offset 1 returns the data bit for output pins and the synchronized pin level for input pins. An input change shows up two clock edges after it is applied.
- R4: Offset 3 selects edge mode per pin (0 = level). In level mode with polarity (offset 2) at 0, the pin is active while its synchronized level is high. The interrupt follows the pin two edges after a change, both when it rises and when it falls, and does not latch.
- R5: In level mode with polarity 1, the pin is active while its synchronized level is low.
- R6: In edge mode with offset 4 (both-edges select) at 0 and polarity 0, a rising input sets the pin's status bit on the third clock edge after the change. A falling input sets nothing.
- R7: In single-edge mode with polarity 1, only a falling input sets the status bit.
- R8: In edge mode with the both-edges bit set, rising and falling inputs each set the status bit, whatever the polarity.
- R9: The status register at offset 7 is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: Writing 1 to a bit of offset 8 sets that pin's status bit on the same write edge, for input and output pins alike.
- R11: irq_a_o is the OR of active pins masked by offset 5, and irq_b_o is the OR of active pins masked by offset 6. A pin that is not in a mask never drives that line.
- R12: Pins configured as outputs produce no hardware level or edge activity, whatever the pin input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pin_i | input | 16 | Pin levels from the pads |
| pad_o | output | 16 | Output pin levels |
| pad_oe_o | output | 16 | Output enables, one per pin |
| irq_a_o | output | 1 | Interrupt line A |
| irq_b_o | output | 1 | Interrupt line B |

## Verification
The pins are driven with single-pin steps up and down under each of the five detection settings: level high, level low, rising edge, falling edge and both edges. Each setting has its own counterpart stimulus, which tells a correct polarity or edge choice from an inverted one. Each step is sampled one edge before and at the edge where a response is due, which catches a missing or extra synchronizer stage and a level pin that wrongly latches. Masks are set to A only or B only to expose cross routing. Output-direction pins are toggled to show they cannot interrupt, and software triggers are tried on both input and output pins.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] REG_DIR    = 4'd0;
  localparam logic [ADDR_W-1:0] REG_DATA   = 4'd1;
  localparam logic [ADDR_W-1:0] REG_POL    = 4'd2;
  localparam logic [ADDR_W-1:0] REG_EDGE   = 4'd3;
  localparam logic [ADDR_W-1:0] REG_BOTH   = 4'd4;
  localparam logic [ADDR_W-1:0] REG_MASK_A = 4'd5;
  localparam logic [ADDR_W-1:0] REG_MASK_B = 4'd6;
  localparam logic [ADDR_W-1:0] REG_STATUS = 4'd7;
  localparam logic [ADDR_W-1:0] REG_SWTRIG = 4'd8;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/flag_detect.sv
module flag_detect #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] sw_set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o,
  output logic [N-1:0] status_o,
  output logic [N-1:0] active_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] status_q;
  logic [N-1:0] lvl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= sync_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise, fall, hit;
    assign rise = sync_i[i] & ~prev_q[i];
    assign fall = ~sync_i[i] & prev_q[i];
    assign hit  = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
    assign evt_o[i]   = ~dir_i[i] & edge_i[i] & hit;
    assign lvl_hit[i] = ~dir_i[i] & ~edge_i[i] & (sync_i[i] ^ pol_i[i]);

    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[i] <= 1'b0;
      else status_q[i] <= (status_q[i] & ~clr_i[i]) | evt_o[i] | sw_set_i[i];
    end
  end

  assign status_o = status_q;
  assign active_o = status_q | lvl_hit;
endmodule

// File: rtl/flag_regs.sv
module flag_regs
  import flag_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      status_i,
  input  logic [N-1:0]      sync_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      data_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      edge_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      mask_a_o,
  output logic [N-1:0]      mask_b_o,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      sw_set_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o    <= '0;
      data_o   <= '0;
      pol_o    <= '0;
      edge_o   <= '0;
      both_o   <= '0;
      mask_a_o <= '0;
      mask_b_o <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_DIR:    dir_o    <= wdata_i;
        REG_DATA:   data_o   <= wdata_i;
        REG_POL:    pol_o    <= wdata_i;
        REG_EDGE:   edge_o   <= wdata_i;
        REG_BOTH:   both_o   <= wdata_i;
        REG_MASK_A: mask_a_o <= wdata_i;
        REG_MASK_B: mask_b_o <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o    = (wr_en_i && addr_i == REG_STATUS) ? wdata_i : '0;
  assign sw_set_o = (wr_en_i && addr_i == REG_SWTRIG) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_DIR:    rdata_o = dir_o;
      REG_DATA:   rdata_o = (dir_o & data_o) | (~dir_o & sync_i);
      REG_POL:    rdata_o = pol_o;
      REG_EDGE:   rdata_o = edge_o;
      REG_BOTH:   rdata_o = both_o;
      REG_MASK_A: rdata_o = mask_a_o;
      REG_MASK_B: rdata_o = mask_b_o;
      REG_STATUS: rdata_o = status_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flag_irq_unit.sv
module flag_irq_unit
  import flag_pkg::*;
#(
  parameter int N_PINS      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  logic [N_PINS-1:0] sync_w, dir_q, data_q, pol_q, edge_q, both_q;
  logic [N_PINS-1:0] mask_a_q, mask_b_q, clr_w, sw_w, evt_w, status_q, active_w;

  flag_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_w)
  );

  flag_regs #(.N(N_PINS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .status_i(status_q), .sync_i(sync_w), .rdata_o,
    .dir_o(dir_q), .data_o(data_q), .pol_o(pol_q), .edge_o(edge_q),
    .both_o(both_q), .mask_a_o(mask_a_q), .mask_b_o(mask_b_q),
    .clr_o(clr_w), .sw_set_o(sw_w)
  );

  flag_detect #(.N(N_PINS)) u_det (
    .clk_i, .rst_ni, .sync_i(sync_w), .dir_i(dir_q), .pol_i(pol_q),
    .edge_i(edge_q), .both_i(both_q), .sw_set_i(sw_w), .clr_i(clr_w),
    .evt_o(evt_w), .status_o(status_q), .active_o(active_w)
  );

  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;
  assign irq_a_o  = |(active_w & mask_a_q);
  assign irq_b_o  = |(active_w & mask_b_q);
endmodule

module flag_irq_unit_chk
  import flag_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic              irq_a_o,
  input logic              irq_b_o,
  input logic [N_PINS-1:0] dir_q,
  input logic [N_PINS-1:0] mask_a_q,
  input logic [N_PINS-1:0] mask_b_q,
  input logic [N_PINS-1:0] status_q,
  input logic [N_PINS-1:0] evt_w
);
  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR) |=> pad_oe_o == $past(wdata_i));

  // R11
  mask_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_a_q == '0) |-> !irq_a_o);

  // R11
  mask_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_b_q == '0) |-> !irq_b_o);

  // R12
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == '1 && status_q == '0) |-> (!irq_a_o && !irq_b_o));

  // R9
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_STATUS && wdata_i == '1 && evt_w == '0) |=> status_q == '0);

  // R10
  status_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q)) != '0) |->
      ($past(evt_w) != '0 || ($past(wr_en_i) && $past(addr_i) == REG_SWTRIG)));
endmodule

bind flag_irq_unit flag_irq_unit_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .pad_oe_o, .irq_a_o, .irq_b_o,
  .dir_q, .mask_a_q, .mask_b_q, .status_q, .evt_w
);

// File: tb/flag_irq_unit_tb.sv
module flag_irq_unit_tb;
  logic        clk_i = 0, rst_ni = 0, wr_en_i = 0;
  logic [3:0]  addr_i = 0;
  logic [15:0] wdata_i = 0, pin_i = 0;
  logic [15:0] rdata_o, pad_o, pad_oe_o;
  logic        irq_a_o, irq_b_o;
  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  flag_irq_unit u_dut (.*);

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [15:0] exp);
    addr_i = a; #1; chk(tag, rdata_o, exp);
  endtask

  task automatic pin(logic [15:0] v);
    @(negedge clk_i); pin_i = v;
  endtask

  task automatic stepn(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd("R1 reg", 4'(a), 16'h0);
    chk("R1 oe", pad_oe_o, 16'h0);
    chk("R1 irq", {14'h0, irq_a_o, irq_b_o}, 16'h0);
  endtask

  task automatic t_output;
    wr(0, 16'h00F0); wr(1, 16'h00A0);
    chk("R2 oe", pad_oe_o, 16'h00F0);
    chk("R2 pad", pad_o & 16'h00F0, 16'h00A0);
    pin(16'h00F5); stepn(1);
    rd("R3 one edge", 1, 16'h00A0);
    stepn(1);
    rd("R3 two edges", 1, 16'h00A5);
    pin(16'h0000); stepn(3);
    wr(0, 16'h0);
  endtask

  task automatic t_level_high;
    wr(5, 16'h0001);
    pin(16'h0001); stepn(1);
    chk("R4 early", {15'h0, irq_a_o}, 16'h0);
    stepn(1);
    chk("R4 high", {15'h0, irq_a_o}, 16'h1);
    chk("R11 b idle", {15'h0, irq_b_o}, 16'h0);
    pin(16'h0000); stepn(2);
    chk("R4 no latch", {15'h0, irq_a_o}, 16'h0);
    rd("R4 status", 7, 16'h0);
    wr(5, 16'h0);
  endtask

  task automatic t_level_low;
    pin(16'h0004); stepn(3);
    wr(2, 16'h0004); wr(6, 16'h0004);
    chk("R5 idle", {15'h0, irq_b_o}, 16'h0);
    pin(16'h0000); stepn(2);
    chk("R5 low", {15'h0, irq_b_o}, 16'h1);
    chk("R11 a unrouted", {15'h0, irq_a_o}, 16'h0);
    wr(6, 16'h0); wr(2, 16'h0);
  endtask

  task automatic t_edge_rise;
    wr(3, 16'h0008); wr(5, 16'h0008);
    pin(16'h0008); stepn(2);
    chk("R6 early", {15'h0, irq_a_o}, 16'h0);
    stepn(1);
    chk("R6 rise", {15'h0, irq_a_o}, 16'h1);
    pin(16'h0000); stepn(3);
    rd("R9 sticky", 7, 16'h0008);
    wr(7, 16'h0000);
    rd("R9 write 0", 7, 16'h0008);
    wr(7, 16'h0008);
    rd("R9 cleared", 7, 16'h0);
    chk("R9 irq off", {15'h0, irq_a_o}, 16'h0);
    pin(16'h0008); stepn(4); wr(7, 16'h0008);
    pin(16'h0000); stepn(4);
    rd("R6 fall ignored", 7, 16'h0);
  endtask

  task automatic t_edge_fall;
    wr(2, 16'h0008);
    pin(16'h0008); stepn(4);
    rd("R7 rise ignored", 7, 16'h0);
    pin(16'h0000); stepn(3);
    rd("R7 fall", 7, 16'h0008);
    wr(7, 16'hFFFF);
  endtask

  task automatic t_both;
    wr(4, 16'h0008);
    pin(16'h0008); stepn(3);
    rd("R8 rise", 7, 16'h0008);
    wr(7, 16'h0008);
    pin(16'h0000); stepn(3);
    rd("R8 fall", 7, 16'h0008);
    wr(7, 16'h0008);
    wr(4, 0); wr(2, 0); wr(3, 0); wr(5, 0);
  endtask

  task automatic t_sw;
    wr(6, 16'h8000);
    wr(8, 16'h8000);
    rd("R10 input pin", 7, 16'h8000);
    chk("R10 irq", {15'h0, irq_b_o}, 16'h1);
    wr(7, 16'h8000);
    wr(0, 16'h4000); wr(8, 16'h4000);
    rd("R10 output pin", 7, 16'h4000);
    wr(7, 16'hFFFF); wr(6, 0); wr(0, 0);
  endtask

  task automatic t_out_quiet;
    wr(0, 16'h0002); wr(2, 16'h0002); wr(5, 16'h0002);
    stepn(3);
    chk("R12 level", {15'h0, irq_a_o}, 16'h0);
    wr(3, 16'h0002); wr(4, 16'h0002);
    pin(16'h0002); stepn(4); pin(16'h0000); stepn(4);
    rd("R12 edge", 7, 16'h0);
    chk("R12 irq", {15'h0, irq_a_o}, 16'h0);
  endtask

  initial begin
    fork
      begin
        stepn(3); rst_ni = 1; stepn(1);
        t_reset; t_output; t_level_high; t_level_low;
        t_edge_rise; t_edge_fall; t_both; t_sw; t_out_quiet;
      end
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule